// File: doc/BRIEF.md
# Interrupt Control and Flag Register

This block is the 8-bit interrupt control register of a small microcontroller core. It combines the enable bits and the sticky event flags for three interrupt sources: a timer overflow, an external pin event, and a change on a 4-bit port input. It also produces the single interrupt request line to the core. The CPU reaches the register over a simple register bus made of an address, a read strobe, a write strobe and data lines. The register decodes at two addresses, one in each of two register banks.

A flag is raised by its event whatever the enable bits hold. Once set, it stays set until software writes a 0 to it. The port-change flag is different from the other two. It does not follow a pulse. It follows a level mismatch between the synchronized port pins and a 4-bit snapshot. That snapshot is reloaded only when the CPU reads the port address. Until that read happens, a software clear of the port-change flag is overridden at once.

The request is gated at two levels. The global enable gates everything. The peripheral-group enable then gates the request coming from outside peripherals. The timer, pin-edge logic and peripheral sources are outside this block, and their events arrive already synchronous to the clock.

Top module: `irq_ctl_reg`

## Requirements
- R1: After synchronous active-low reset every register bit reads 0, including the port-change flag (0 is the chosen value for that undefined bit), and the request output is 0.
- R2: A read with address bits [6:0] equal to 0x0B (so 0x0B or 0x8B) returns the register on the read data lines. Bit 7 is global enable, bit 6 peripheral enable, bit 5 timer enable, bit 4 pin enable, bit 3 port-change enable, bit 2 timer flag, bit 1 pin flag and bit 0 port-change flag. In any other cycle the read data lines are 0.
- R3: A write at 0x0B or 0x8B loads all 8 bits from the write data. A write to any other address leaves the register unchanged.
- R4: A timer overflow event pulse sets bit 2 at the next clock edge, whatever the enable bits hold.
- R5: An external pin event pulse sets bit 1 at the next clock edge, whatever the enable bits hold.
- R6: Flags are sticky. They stay set across idle cycles and clear only when software writes 0 to them. Writing 1 sets them.
- R7: When a flag's event and a software write of 0 to that flag fall in the same cycle, the flag ends set.
- R8: The port pins pass through two synchronizer flops. Bit 0 becomes 1 on the third clock edge after the pins start to differ from the snapshot, and it does not become 1 if they match.
- R9: The mismatch holds until a read of the port address (bits [6:0] equal to 0x06, so 0x06 or 0x86) reloads the snapshot from the synchronized pins. A write of 0 to bit 0 before that read leaves bit 0 at 1. The same write after the read clears it.
- R10: The request output equals global enable AND (timer enable AND timer flag, OR pin enable AND pin flag, OR port-change enable AND port-change flag, OR peripheral enable AND the peripheral request input). It follows the register and input with no added delay.
- R11: With global enable 0 the request is 0 for every other state. With peripheral enable 0 the peripheral request input has no effect on the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register bus address, bit 7 selects the bank |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when the register is not being read |
| tmr_ovf_evt | input | 1 | Timer overflow event pulse |
| pin_evt | input | 1 | External pin event pulse, after edge selection |
| port_pins | input | 4 | Upper port pins watched for change, asynchronous |
| periph_req | input | 1 | Combined request from the peripheral group |
| irq | output | 1 | Interrupt request to the core |

## Verification
The hardest state to reach is a port-change flag that software cannot clear. To get there, the pins must differ from a snapshot that only a read at another address can refresh, and the three-edge synchronizer latency must be respected. The bench sweeps all sixteen pin values in a scrambled order, with the previous snapshot tracked in the bench. For each value it samples bit 0 after each of the first three edges. It then tries a clear before the port read and again after a port read, alternating the two bank addresses of the port. Same-cycle set/clear collisions are forced by holding an event pulse high during the clearing write.

// File: rtl/irq_ctl_pkg.sv
// Package irq_ctl_pkg
// Shared bit positions and source indices for the interrupt control register.
// Assumes source i has its flag at bit i and its enable at bit i + SRC_CNT.
package irq_ctl_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned SRC_CNT = 3;

    // Source index, equal to the flag bit position
    typedef enum logic [1:0] {
        SRC_CHG = 2'd0,
        SRC_PIN = 2'd1,
        SRC_TMR = 2'd2
    } irq_src_e;

    localparam int unsigned BIT_GLOBAL = 7;
    localparam int unsigned BIT_PERIPH = 6;
    localparam int unsigned EN_LSB     = SRC_CNT;
endpackage

// File: rtl/irq_pin_sync.sv
// Module irq_pin_sync
// Multi-stage synchronizer for a bus of independent asynchronous pins.
// Assumes each bit is sampled on its own; no cross-bit coherence is promised.
module irq_pin_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_async,
    output logic [W-1:0] pins_sync
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the pin samples through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= pins_async;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign pins_sync = stage_q[STAGES-1];
endmodule

// File: rtl/irq_change_det.sv
// Module irq_change_det
// Holds a snapshot of the synchronized port pins and reports a level mismatch.
// Assumes the snapshot is reloaded only by a port read; mismatch persists until then.
module irq_change_det #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_sync,
    input  logic         snap_load,
    output logic         mismatch
);
    logic [W-1:0] snap_q;

    // Reload the snapshot on a port read
    always_ff @(posedge clk) begin
        if (!rst_n)         snap_q <= '0;
        else if (snap_load) snap_q <= pins_sync;
    end

    // Any differing pin is a change condition
    assign mismatch = |(pins_sync ^ snap_q);
endmodule

// File: rtl/irq_flag_cell.sv
// Module irq_flag_cell
// One sticky interrupt flag: hardware sets it, software writes it.
// Assumes a hardware set in the same cycle as a software write takes priority.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_wr,
    input  logic sw_val,
    output logic flag
);
    logic flag_q;

    // Sticky update with set priority over software
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (hw_set) flag_q <= 1'b1;
        else if (sw_wr)  flag_q <= sw_val;
    end

    assign flag = flag_q;
endmodule

// File: rtl/irq_req_gate.sv
// Module irq_req_gate
// Two-level request gating: per-source enable, peripheral group, then global.
// Assumes all inputs are registered or synchronous; output is combinational.
module irq_req_gate #(
    parameter int unsigned N_SRC = 3
) (
    input  logic             global_en,
    input  logic             periph_en,
    input  logic [N_SRC-1:0] src_en,
    input  logic [N_SRC-1:0] src_flag,
    input  logic             periph_req,
    output logic             irq
);
    logic [N_SRC:0] term;

    // Per-source enable gating
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign term[i] = src_en[i] & src_flag[i];
    end

    // Peripheral group gating
    assign term[N_SRC] = periph_en & periph_req;

    // Global gating over all terms
    assign irq = global_en & (|term);
endmodule

// File: rtl/irq_ctl_reg.sv
// Module irq_ctl_reg
// Interrupt control and flag register with two bank-mirrored bus addresses,
// a port-change detector and two-level request gating.
// Assumes event inputs are single-cycle synchronous pulses and port_pins is async.
module irq_ctl_reg
    import irq_ctl_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 8,
    parameter int unsigned        PORT_W      = 4,
    parameter int unsigned        SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0]  REG_OFS     = 8'h0B,
    parameter logic [ADDR_W-1:0]  PORT_OFS    = 8'h06,
    parameter logic [ADDR_W-1:0]  BANK_MASK   = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tmr_ovf_evt,
    input  logic              pin_evt,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              periph_req,
    output logic              irq
);
    localparam int unsigned EN_W = REG_W - SRC_CNT;

    logic               reg_hit, port_hit, reg_wr, port_rd;
    logic [PORT_W-1:0]  pins_sync;
    logic               chg_mismatch;
    logic [EN_W-1:0]    en_q;
    logic [SRC_CNT-1:0] hw_set, flag_vec;
    logic [REG_W-1:0]   reg_q;

    // Address decode, ignoring the bank-select bits
    assign reg_hit  = ((bus_addr ^ REG_OFS)  & ~BANK_MASK) == '0;
    assign port_hit = ((bus_addr ^ PORT_OFS) & ~BANK_MASK) == '0;
    assign reg_wr   = bus_wr & reg_hit;
    assign port_rd  = bus_rd & port_hit;

    irq_pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async (port_pins),
        .pins_sync  (pins_sync)
    );

    irq_change_det #(.W(PORT_W)) u_chg (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_sync (pins_sync),
        .snap_load (port_rd),
        .mismatch  (chg_mismatch)
    );

    // Enable bits load only on a write at the register address
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (reg_wr) en_q <= bus_wdata[REG_W-1:EN_LSB];
    end

    // Hardware set sources, indexed by flag position
    assign hw_set[SRC_CHG] = chg_mismatch;
    assign hw_set[SRC_PIN] = pin_evt;
    assign hw_set[SRC_TMR] = tmr_ovf_evt;

    for (genvar i = 0; i < SRC_CNT; i++) begin : g_flag
        irq_flag_cell u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (hw_set[i]),
            .sw_wr  (reg_wr),
            .sw_val (bus_wdata[i]),
            .flag   (flag_vec[i])
        );
    end

    assign reg_q = {en_q, flag_vec};

    // Read mux: register value only while it is being read
    assign bus_rdata = (bus_rd && reg_hit) ? reg_q : '0;

    irq_req_gate #(.N_SRC(SRC_CNT)) u_gate (
        .global_en  (reg_q[BIT_GLOBAL]),
        .periph_en  (reg_q[BIT_PERIPH]),
        .src_en     (reg_q[EN_LSB+SRC_CNT-1:EN_LSB]),
        .src_flag   (flag_vec),
        .periph_req (periph_req),
        .irq        (irq)
    );
endmodule

// File: rtl/irq_ctl_reg_chk.sv
// Module irq_ctl_reg_chk
// Property checker for irq_ctl_reg, attached by bind below.
// Assumes reg_q is the assembled 8-bit register in the documented layout.
module irq_ctl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] wdata,
    input logic [7:0] reg_q,
    input logic       tmr_evt,
    input logic       pin_evt,
    input logic       mismatch,
    input logic       periph_req,
    input logic       irq
);
    // R4
    tmr_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt |=> reg_q[2]);

    // R5
    pin_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_evt |=> reg_q[1]);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q[2] && !(reg_wr && !wdata[2])) |=> reg_q[2]);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_evt && reg_wr && !wdata[1]) |=> reg_q[1]);

    // R9
    chg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> reg_q[0]);

    // R3
    enables_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(reg_q[7:3]));

    // R11
    global_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_q[7] |-> !irq);

    // R11
    periph_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_q[6] && ((reg_q[5:3] & reg_q[2:0]) == 3'b000)) |-> !irq);

    // R10
    req_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q[7] && ((|(reg_q[5:3] & reg_q[2:0])) || (reg_q[6] && periph_req))) |-> irq);
endmodule

bind irq_ctl_reg irq_ctl_reg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .wdata      (bus_wdata),
    .reg_q      (reg_q),
    .tmr_evt    (tmr_ovf_evt),
    .pin_evt    (pin_evt),
    .mismatch   (chg_mismatch),
    .periph_req (periph_req),
    .irq        (irq)
);

// File: tb/irq_ctl_reg_bench.sv
`timescale 1ns/100ps
// Bench for irq_ctl_reg: full sweep of register values against the gating
// equation, then flag, collision and port-change sequences.
module irq_ctl_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic       bus_rd, bus_wr, tmr_ovf_evt, pin_evt, periph_req, irq;
    logic [3:0] port_pins;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctl_reg u_irq_ctl_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .tmr_ovf_evt (tmr_ovf_evt),
        .pin_evt     (pin_evt),
        .port_pins   (port_pins),
        .periph_req  (periph_req),
        .irq         (irq)
    );

    // Compare one value and log a miscompare
    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // Advance one clock; return at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #0.5;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic port_read(input logic [7:0] a);
        bus_addr = a; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       exp_irq;
        logic [3:0] prev;
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_rd = 1'b0; bus_wr = 1'b0;
        tmr_ovf_evt = 1'b0; pin_evt = 1'b0; port_pins = '0; periph_req = 1'b0;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd(8'h0B, d);
        chk("R1 reset register", d, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);

        // R2, R3, R10, R11: every register value, both banks, both peripheral levels
        for (int v = 0; v < 256; v++) begin
            wr(v[0] ? 8'h8B : 8'h0B, v[7:0]);
            rd(v[1] ? 8'h0B : 8'h8B, d);
            chk("R2 R3 readback", d, v[7:0]);
            for (int p = 0; p < 2; p++) begin
                periph_req = p[0];
                #0.5;
                exp_irq = v[7] & ((|(v[5:3] & v[2:0])) | (v[6] & p[0]));
                if (!v[7] || !v[6]) chk("R11 gating", {7'd0, irq}, {7'd0, exp_irq});
                else                chk("R10 request", {7'd0, irq}, {7'd0, exp_irq});
            end
            periph_req = 1'b0;
        end

        // R2: unselected read returns 0
        wr(8'h0B, 8'hC3);
        rd(8'h0C, d);
        chk("R2 unselected read", d, 8'h00);

        // R3: writes elsewhere leave the register alone
        wr(8'h0B, 8'hA8);
        wr(8'h0C, 8'hFF);
        wr(8'h4B, 8'h57);
        wr(8'h8A, 8'h00);
        wr(8'h06, 8'h11);
        rd(8'h8B, d);
        chk("R3 foreign writes", d, 8'hA8);

        // R4, R5: events set flags with all enables off
        wr(8'h0B, 8'h00);
        tmr_ovf_evt = 1'b1; tick(); tmr_ovf_evt = 1'b0;
        rd(8'h0B, d);
        chk("R4 timer flag", d, 8'h04);
        pin_evt = 1'b1; tick(); pin_evt = 1'b0;
        rd(8'h0B, d);
        chk("R5 pin flag", d, 8'h06);

        // R6: sticky, software clear, software set
        repeat (8) tick();
        rd(8'h0B, d);
        chk("R6 sticky", d, 8'h06);
        wr(8'h0B, 8'h00);
        rd(8'h0B, d);
        chk("R6 clear", d, 8'h00);
        wr(8'h8B, 8'h07);
        rd(8'h0B, d);
        chk("R6 software set", d, 8'h07);
        wr(8'h0B, 8'h00);

        // R7: same-cycle set and clear
        tmr_ovf_evt = 1'b1; wr(8'h0B, 8'h00); tmr_ovf_evt = 1'b0;
        rd(8'h0B, d);
        chk("R7 timer set wins", d, 8'h04);
        pin_evt = 1'b1; wr(8'h8B, 8'h00); pin_evt = 1'b0;
        rd(8'h0B, d);
        chk("R7 pin set wins", d, 8'h02);
        wr(8'h0B, 8'h00);

        // R8, R9: all pin values in scrambled order
        prev = 4'h0;
        for (int i = 0; i < 16; i++) begin
            logic [3:0] nv;
            nv = 4'((i * 7 + 3) % 16);
            port_pins = nv;
            tick();
            rd(8'h0B, d);
            chk("R8 after edge 1", {7'd0, d[0]}, 8'h00);
            tick();
            rd(8'h0B, d);
            chk("R8 after edge 2", {7'd0, d[0]}, 8'h00);
            tick();
            rd(8'h0B, d);
            chk("R8 after edge 3", {7'd0, d[0]}, {7'd0, nv != prev});
            wr(8'h0B, 8'h00);
            rd(8'h0B, d);
            chk("R9 clear before port read", {7'd0, d[0]}, {7'd0, nv != prev});
            port_read(i[0] ? 8'h86 : 8'h06);
            wr(8'h0B, 8'h00);
            rd(8'h0B, d);
            chk("R9 clear after port read", {7'd0, d[0]}, 8'h00);
            tick();
            rd(8'h0B, d);
            chk("R9 stays clear", {7'd0, d[0]}, 8'h00);
            prev = nv;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule